// File: doc/BRIEF.md
# PHY Parallel Register Write Master

This block writes 16-bit control registers inside one of two attached PHYs. Each PHY has a parallel register port with an address bus, a write-data bus, a write-enable line, an acknowledge line and a port-select line. A single command carries a target PHY, a register address and a data word. The master puts address and data on the chosen port, raises write-enable, and waits for acknowledge to rise. It then drops write-enable and waits for acknowledge to fall before it finishes. Each of the two waits is bounded by a cycle limit. When a limit runs out, the error flag is set and the write still finishes normally.

A second command kind starts the lane initialisation sequence. The master raises the select line of both PHYs and waits a settle period. It then writes one fixed initialisation word to the per-lane receive-override register of every lane: all lanes of PHY0 first, then all lanes of PHY1. The command fields for target, address and data are not used by this sequence. The upstream agent sees a `busy` level, a one-cycle `done` pulse and a sticky `tmo_err` flag.

Top module: `phy_wr_master`

## Requirements
- R1: After reset, `busy`, `done`, `tmo_err`, both select lines and both write-enables are low, and both address and data buses read zero.
- R2: For each write, address and data are on the port one cycle before write-enable rises, and they do not change while write-enable is high. Write-enable falls in the cycle after acknowledge is sampled high. The write finishes only after acknowledge is sampled low, or after the low-wait limit runs out.
- R3: When `cmd_phy_sel`=0, the write goes to port 0; when it is 1, the write goes to port 1. The port that is not addressed keeps write-enable low and its address and data buses at zero.
- R4: `busy` is high from the cycle after an accepted start until `done`. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R5: A `cmd_start` that arrives while `busy` is high is ignored. It produces no write and no extra `done`.
- R6: If acknowledge never rises, write-enable stays high for exactly ACK_TMO_CYC cycles. It then falls, and the write finishes.
- R7: If acknowledge never falls, `done` comes exactly ACK_TMO_CYC cycles after write-enable falls.
- R8: `tmo_err` is set by either timeout. It stays set while the master is idle and is cleared by the next accepted start.
- R9: An init command raises both select lines in the same cycle, and they stay high until reset. The first write-enable of the sequence rises exactly SETTLE_CYC+2 cycles after the select lines rise.
- R10: The init sequence makes 2×LANES writes, to PHY0 lanes 0 to LANES-1 and then PHY1 lanes 0 to LANES-1. The lane register address is 0x1008 + 0x100 × lane.
- R11: Every init write carries the word 0x0E21, which is bits 0, 5, 9, 10 and 11 set. `cmd_phy_sel`, `cmd_addr` and `cmd_data` have no effect during an init command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse, accepted only while idle |
| cmd_init | input | 1 | 1 = run the lane init sequence, 0 = single write |
| cmd_phy_sel | input | 1 | Target PHY for a single write |
| cmd_addr | input | 16 | Register address for a single write |
| cmd_data | input | 16 | Data word for a single write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| tmo_err | output | 1 | Sticky acknowledge-timeout flag |
| phy0_sel | output | 1 | PHY0 register-port select |
| phy0_addr | output | 16 | PHY0 register address |
| phy0_wdata | output | 16 | PHY0 write data |
| phy0_wr_en | output | 1 | PHY0 write-enable |
| phy0_ack | input | 1 | PHY0 acknowledge |
| phy1_sel | output | 1 | PHY1 register-port select |
| phy1_addr | output | 16 | PHY1 register address |
| phy1_wdata | output | 16 | PHY1 write data |
| phy1_wr_en | output | 1 | PHY1 write-enable |
| phy1_ack | input | 1 | PHY1 acknowledge |

## Verification
The assertions assume that the PHY responder changes acknowledge only in answer to write-enable. They also assume that acknowledge on the port that is not addressed does not matter, and that `cmd_start` is a level sampled at each edge. The bench responder drives acknowledge away from the clock edge, after a fixed delay or not at all. It keeps acknowledge low on idle ports. Each timeout mode is switched back to normal before the next command, so every command starts with acknowledge low on both ports.

// File: rtl/phy_wr_pkg.sv
package phy_wr_pkg;

  localparam int REG_AW = 16;
  localparam int REG_DW = 16;

  typedef logic [REG_AW-1:0] reg_addr_t;
  typedef logic [REG_DW-1:0] reg_data_t;

  // per-lane receive override register: base plus lane stride
  localparam reg_addr_t LANE_REG_BASE = 16'h1008;
  localparam reg_addr_t LANE_REG_STEP = 16'h0100;

  // bit positions of the lane init word
  localparam int B_CDR_TRACK = 0;
  localparam int B_LOS_LVL   = 5;
  localparam int B_TERM_ON   = 9;
  localparam int B_TERM_AC   = 10;
  localparam int B_LANE_ON   = 11;

  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_HI, E_LO} hs_state_e;
  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_ISSUE, S_WAIT} seq_state_e;

  function automatic reg_addr_t lane_reg_addr(input int unsigned lane);
    return LANE_REG_BASE + reg_addr_t'(lane) * LANE_REG_STEP;
  endfunction

  function automatic reg_data_t lane_init_word();
    reg_data_t w;
    w = '0;
    w[B_CDR_TRACK] = 1'b1;
    w[B_LOS_LVL]   = 1'b1;
    w[B_TERM_ON]   = 1'b1;
    w[B_TERM_AC]   = 1'b1;
    w[B_LANE_ON]   = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/phy_wr_hs.sv
module phy_wr_hs
  import phy_wr_pkg::*;
#(
  parameter int ACK_TMO_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic ack,
  output logic wr_en,
  output logic fin,
  output logic tmo
);

  localparam int TW = $clog2(ACK_TMO_CYC + 1);
  localparam logic [TW-1:0] TLIM = TW'(ACK_TMO_CYC - 1);

  hs_state_e     st_q;
  logic [TW-1:0] cnt_q;
  logic          hit;

  assign hit   = (cnt_q == TLIM);
  assign wr_en = (st_q == E_HI);
  assign fin   = (st_q == E_LO) && (!ack || hit);
  assign tmo   = ((st_q == E_HI) && !ack && hit) ||
                 ((st_q == E_LO) &&  ack && hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= E_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        E_IDLE: if (go) st_q <= E_SETUP;
        E_SETUP: begin
          st_q  <= E_HI;
          cnt_q <= '0;
        end
        E_HI: begin
          if (ack || hit) begin
            st_q  <= E_LO;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        E_LO: begin
          if (!ack || hit) begin
            st_q  <= E_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_wr_seq.sv
module phy_wr_seq
  import phy_wr_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int SETTLE_CYC = 10
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_start,
  input  logic      cmd_init,
  input  logic      cmd_phy_sel,
  input  reg_addr_t cmd_addr,
  input  reg_data_t cmd_data,
  input  logic      fin,
  output logic      go,
  output logic      busy,
  output logic      done,
  output logic      start_acc,
  output logic      drive,
  output logic [1:0] sel_en,
  output logic      tgt_phy,
  output reg_addr_t tgt_addr,
  output reg_data_t tgt_data
);

  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);
  localparam logic [SW-1:0] SET_LIM   = SW'(SETTLE_CYC - 1);

  seq_state_e    st_q;
  logic [SW-1:0] set_cnt_q;
  logic [LW-1:0] lane_q, nxt_lane;
  logic          phy_q, nxt_phy, init_q, last_lane, final_wr;
  logic          done_q;
  logic [1:0]    sel_q;
  logic          tgt_phy_q;
  reg_addr_t     addr_q;
  reg_data_t     data_q;

  always_comb begin
    last_lane = (lane_q == LAST_LANE);
    nxt_lane  = last_lane ? '0 : lane_q + 1'b1;
    nxt_phy   = phy_q | last_lane;
    final_wr  = !init_q || (phy_q && last_lane);
  end

  assign go        = (st_q == S_ISSUE);
  assign busy      = (st_q != S_IDLE);
  assign start_acc = (st_q == S_IDLE) && cmd_start;
  assign drive     = (st_q == S_WAIT);
  assign done      = done_q;
  assign sel_en    = sel_q;
  assign tgt_phy   = tgt_phy_q;
  assign tgt_addr  = addr_q;
  assign tgt_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      set_cnt_q <= '0;
      lane_q    <= '0;
      phy_q     <= 1'b0;
      init_q    <= 1'b0;
      done_q    <= 1'b0;
      sel_q     <= 2'b00;
      tgt_phy_q <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (cmd_start) begin
            if (cmd_init) begin
              init_q    <= 1'b1;
              sel_q     <= 2'b11;
              set_cnt_q <= '0;
              lane_q    <= '0;
              phy_q     <= 1'b0;
              st_q      <= S_SETTLE;
            end else begin
              init_q    <= 1'b0;
              tgt_phy_q <= cmd_phy_sel;
              addr_q    <= cmd_addr;
              data_q    <= cmd_data;
              st_q      <= S_ISSUE;
            end
          end
        end
        S_SETTLE: begin
          if (set_cnt_q == SET_LIM) begin
            tgt_phy_q <= 1'b0;
            addr_q    <= lane_reg_addr(0);
            data_q    <= lane_init_word();
            st_q      <= S_ISSUE;
          end else begin
            set_cnt_q <= set_cnt_q + 1'b1;
          end
        end
        S_ISSUE: st_q <= S_WAIT;
        S_WAIT: begin
          if (fin) begin
            if (final_wr) begin
              done_q <= 1'b1;
              st_q   <= S_IDLE;
            end else begin
              lane_q    <= nxt_lane;
              phy_q     <= nxt_phy;
              tgt_phy_q <= nxt_phy;
              addr_q    <= lane_reg_addr(int'(nxt_lane));
              st_q      <= S_ISSUE;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_port_mux.sv
module phy_port_mux
  import phy_wr_pkg::*;
(
  input  logic       tgt_phy,
  input  logic       drive,
  input  logic       wr_en,
  input  reg_addr_t  addr,
  input  reg_data_t  data,
  input  logic [1:0] port_ack,
  output logic [1:0] port_wr_en,
  output reg_addr_t  port_addr [2],
  output reg_data_t  port_data [2],
  output logic       ack_sel
);

  assign ack_sel = port_ack[tgt_phy];

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam logic PID = 1'(p);
    logic hit;
    assign hit           = (tgt_phy == PID);
    assign port_wr_en[p] = wr_en && hit;
    assign port_addr[p]  = (drive && hit) ? addr : '0;
    assign port_data[p]  = (drive && hit) ? data : '0;
  end

endmodule

// File: rtl/phy_wr_master.sv
module phy_wr_master
  import phy_wr_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int SETTLE_CYC  = 10,
  parameter int ACK_TMO_CYC = 500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic        cmd_init,
  input  logic        cmd_phy_sel,
  input  logic [15:0] cmd_addr,
  input  logic [15:0] cmd_data,
  output logic        busy,
  output logic        done,
  output logic        tmo_err,
  output logic        phy0_sel,
  output logic [15:0] phy0_addr,
  output logic [15:0] phy0_wdata,
  output logic        phy0_wr_en,
  input  logic        phy0_ack,
  output logic        phy1_sel,
  output logic [15:0] phy1_addr,
  output logic [15:0] phy1_wdata,
  output logic        phy1_wr_en,
  input  logic        phy1_ack
);

  // named internal events, also observed by the bound checker
  logic       start_acc, eng_go, eng_fin, eng_tmo, eng_wr_en, ack_sel;
  logic       drive, tgt_phy;
  logic [1:0] sel_en, port_wr_en;
  reg_addr_t  tgt_addr;
  reg_data_t  tgt_data;
  reg_addr_t  port_addr [2];
  reg_data_t  port_data [2];
  logic       tmo_q;

  phy_wr_seq #(.LANES(LANES), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_init   (cmd_init),
    .cmd_phy_sel(cmd_phy_sel),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .fin        (eng_fin),
    .go         (eng_go),
    .busy       (busy),
    .done       (done),
    .start_acc  (start_acc),
    .drive      (drive),
    .sel_en     (sel_en),
    .tgt_phy    (tgt_phy),
    .tgt_addr   (tgt_addr),
    .tgt_data   (tgt_data)
  );

  phy_wr_hs #(.ACK_TMO_CYC(ACK_TMO_CYC)) u_hs (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (eng_go),
    .ack  (ack_sel),
    .wr_en(eng_wr_en),
    .fin  (eng_fin),
    .tmo  (eng_tmo)
  );

  phy_port_mux u_mux (
    .tgt_phy   (tgt_phy),
    .drive     (drive),
    .wr_en     (eng_wr_en),
    .addr      (tgt_addr),
    .data      (tgt_data),
    .port_ack  ({phy1_ack, phy0_ack}),
    .port_wr_en(port_wr_en),
    .port_addr (port_addr),
    .port_data (port_data),
    .ack_sel   (ack_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          tmo_q <= 1'b0;
    else if (start_acc)  tmo_q <= 1'b0;
    else if (eng_tmo)    tmo_q <= 1'b1;
  end

  assign tmo_err    = tmo_q;
  assign phy0_sel   = sel_en[0];
  assign phy1_sel   = sel_en[1];
  assign phy0_wr_en = port_wr_en[0];
  assign phy1_wr_en = port_wr_en[1];
  assign phy0_addr  = port_addr[0];
  assign phy1_addr  = port_addr[1];
  assign phy0_wdata = port_data[0];
  assign phy1_wdata = port_data[1];

endmodule

// File: rtl/phy_wr_master_chk.sv
module phy_wr_master_chk #(
  parameter int ACK_TMO_CYC = 500
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        tmo_err,
  input logic        start_acc,
  input logic        eng_tmo,
  input logic        phy0_sel,
  input logic        phy1_sel,
  input logic        phy0_wr_en,
  input logic        phy1_wr_en,
  input logic        phy0_ack,
  input logic        phy1_ack,
  input logic [15:0] phy0_addr,
  input logic [15:0] phy1_addr,
  input logic [15:0] phy0_wdata,
  input logic [15:0] phy1_wdata
);

  logic [31:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                        hi_run <= '0;
    else if (phy0_wr_en || phy1_wr_en) hi_run <= hi_run + 1;
    else                               hi_run <= '0;
  end

  p_one_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(phy0_wr_en && phy1_wr_en));

  p_hold0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phy0_wr_en && $past(phy0_wr_en)) |-> ($stable(phy0_addr) && $stable(phy0_wdata)));

  p_hold1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phy1_wr_en && $past(phy1_wr_en)) |-> ($stable(phy1_addr) && $stable(phy1_wdata)));

  p_drop0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phy0_wr_en && phy0_ack) |=> !phy0_wr_en);

  p_drop1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phy1_wr_en && phy1_ack) |=> !phy1_wr_en);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy);

  p_hi_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= 32'(ACK_TMO_CYC));

  p_tmo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_err && !start_acc) |=> tmo_err);

  p_tmo_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err) |-> $past(eng_tmo));

  p_sel_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phy0_sel == phy1_sel);

  p_sel_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phy0_sel |=> phy0_sel);

endmodule

bind phy_wr_master phy_wr_master_chk #(.ACK_TMO_CYC(ACK_TMO_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .tmo_err   (tmo_err),
  .start_acc (start_acc),
  .eng_tmo   (eng_tmo),
  .phy0_sel  (phy0_sel),
  .phy1_sel  (phy1_sel),
  .phy0_wr_en(phy0_wr_en),
  .phy1_wr_en(phy1_wr_en),
  .phy0_ack  (phy0_ack),
  .phy1_ack  (phy1_ack),
  .phy0_addr (phy0_addr),
  .phy1_addr (phy1_addr),
  .phy0_wdata(phy0_wdata),
  .phy1_wdata(phy1_wdata)
);

// File: tb/phy_wr_master_tb.sv
module phy_wr_master_tb;

  localparam int LANES  = 4;
  localparam int SETTLE = 10;
  localparam int TMO    = 40;
  localparam logic [15:0] INIT_WORD = 16'h0E21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_init = 1'b0, cmd_phy_sel = 1'b0;
  logic [15:0] cmd_addr = '0, cmd_data = '0;
  logic busy, done, tmo_err;
  logic phy0_sel, phy0_wr_en, phy1_sel, phy1_wr_en;
  logic [15:0] phy0_addr, phy0_wdata, phy1_addr, phy1_wdata;
  logic phy0_ack, phy1_ack;

  always #5ns clk = ~clk;

  phy_wr_master #(.LANES(LANES), .SETTLE_CYC(SETTLE), .ACK_TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_init(cmd_init),
    .cmd_phy_sel(cmd_phy_sel), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .busy(busy), .done(done), .tmo_err(tmo_err),
    .phy0_sel(phy0_sel), .phy0_addr(phy0_addr), .phy0_wdata(phy0_wdata),
    .phy0_wr_en(phy0_wr_en), .phy0_ack(phy0_ack),
    .phy1_sel(phy1_sel), .phy1_addr(phy1_addr), .phy1_wdata(phy1_wdata),
    .phy1_wr_en(phy1_wr_en), .phy1_ack(phy1_ack)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // responder and monitor state
  int          mode [2];      // 0 normal, 1 never ack, 2 ack stuck high
  int          dly [2];
  int          rcnt [2];
  logic        ack_r [2];
  logic        prev_we [2], prev_ack [2];
  logic [15:0] prev_ad [2], prev_dt [2];
  int          run [2], last_run [2], fall_cyc [2];
  int          cyc = 0;
  int          nwrites = 0;
  int          cur_port = -1;
  int          sel_rise_cyc = 0, first_we_cyc = 0, last_done_cyc = 0;
  bit          want_first = 1'b0;
  logic        prev_sel = 1'b0;
  logic [32:0] exp_q [$];

  assign phy0_ack = ack_r[0];
  assign phy1_ack = ack_r[1];

  initial begin
    for (int p = 0; p < 2; p++) begin
      mode[p] = 0; dly[p] = 1; rcnt[p] = 0; ack_r[p] = 1'b0;
      prev_we[p] = 1'b0; prev_ack[p] = 1'b0; prev_ad[p] = '0; prev_dt[p] = '0;
      run[p] = 0; last_run[p] = 0; fall_cyc[p] = 0;
    end
  end

  always @(negedge clk) begin
    logic        we [2];
    logic [15:0] ad [2], dt [2];
    logic [32:0] e;
    we[0] = phy0_wr_en; we[1] = phy1_wr_en;
    ad[0] = phy0_addr;  ad[1] = phy1_addr;
    dt[0] = phy0_wdata; dt[1] = phy1_wdata;
    cyc++;
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        ack_r[p] = 1'b0; rcnt[p] = 0; prev_we[p] = 1'b0; prev_ack[p] = 1'b0;
        prev_ad[p] = '0; prev_dt[p] = '0; run[p] = 0;
      end
      prev_sel = 1'b0;
    end else begin
      if (done) last_done_cyc = cyc;
      check(phy0_sel == phy1_sel, "R9 select pair", {32'd0, phy0_sel}, {32'd0, phy1_sel});
      if (phy0_sel && !prev_sel) begin
        sel_rise_cyc = cyc;
        want_first = 1'b1;
      end
      prev_sel = phy0_sel;
      for (int p = 0; p < 2; p++) begin
        if (prev_we[p] && prev_ack[p])
          check(!we[p], "R2 enable drop after ack", {32'd0, we[p]}, 33'd0);
        if (we[p] && !prev_we[p]) begin
          check(prev_ad[p] == ad[p] && prev_dt[p] == dt[p], "R2 setup before enable",
                {1'b0, prev_ad[p], prev_dt[p]}, {1'b0, ad[p], dt[p]});
          nwrites++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected write", {1'(p), ad[p], dt[p]}, 33'd0);
          end else begin
            e = exp_q.pop_front();
            check({1'(p), ad[p], dt[p]} == e, "R3/R10/R11 write content",
                  {1'(p), ad[p], dt[p]}, e);
          end
          if (want_first) begin
            first_we_cyc = cyc;
            want_first = 1'b0;
          end
        end
        if (we[p] && prev_we[p])
          check(ad[p] == prev_ad[p] && dt[p] == prev_dt[p], "R2 hold while enabled",
                {1'b0, ad[p], dt[p]}, {1'b0, prev_ad[p], prev_dt[p]});
        if (we[p]) run[p]++;
        else if (prev_we[p]) begin
          last_run[p] = run[p];
          fall_cyc[p] = cyc;
          run[p] = 0;
        end
        if (cur_port >= 0 && p != cur_port)
          check(!we[p] && ad[p] == 0 && dt[p] == 0, "R3 other port quiet",
                {we[p], ad[p], dt[p]}, 33'd0);
        prev_we[p] = we[p];
        prev_ad[p] = ad[p];
        prev_dt[p] = dt[p];
        // responder
        case (mode[p])
          0: begin
            if (we[p] && !ack_r[p]) begin
              rcnt[p]++;
              if (rcnt[p] >= dly[p]) begin ack_r[p] = 1'b1; rcnt[p] = 0; end
            end else if (!we[p] && ack_r[p]) begin
              rcnt[p]++;
              if (rcnt[p] >= dly[p]) begin ack_r[p] = 1'b0; rcnt[p] = 0; end
            end else rcnt[p] = 0;
          end
          1: ack_r[p] = 1'b0;
          default: if (we[p]) ack_r[p] = 1'b1;
        endcase
        prev_ack[p] = ack_r[p];
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_cmd(input logic init, input logic ps, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_init = init; cmd_phy_sel = ps; cmd_addr = a; cmd_data = d; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (n < 3000) begin
      @(negedge clk);
      n++;
      if (done) break;
      check(busy, "R4 busy during command", {32'd0, busy}, 33'd1);
    end
    check(done, "R4 done reached", {32'd0, done}, 33'd1);
    check(!busy, "R4 busy low with done", {32'd0, busy}, 33'd0);
    @(negedge clk);
    check(!done, "R4 done single cycle", {32'd0, done}, 33'd0);
  endtask

  task automatic check_idle(input string req);
    check({busy, done, tmo_err, phy0_sel, phy1_sel, phy0_wr_en, phy1_wr_en} == 7'd0,
          req, {26'd0, busy, done, tmo_err, phy0_sel, phy1_sel, phy0_wr_en, phy1_wr_en}, 33'd0);
    check({phy0_addr, phy0_wdata} == 32'd0 && {phy1_addr, phy1_wdata} == 32'd0, req,
          {1'b0, phy0_addr | phy1_addr, phy0_wdata | phy1_wdata}, 33'd0);
  endtask

  initial begin
    int w0;
    do_reset();
    repeat (2) @(negedge clk);
    check_idle("R1 reset state");

    // single write to PHY0, short ack delay
    cur_port = 0; dly[0] = 1;
    exp_q.push_back({1'b0, 16'h0123, 16'hBEEF});
    do_cmd(1'b0, 1'b0, 16'h0123, 16'hBEEF);
    wait_done();
    check(exp_q.size() == 0, "R3 write to port 0", exp_q.size(), 33'd0);
    check(!tmo_err, "R8 no timeout", {32'd0, tmo_err}, 33'd0);

    // single write to PHY1, longer ack delay
    cur_port = 1; dly[1] = 3;
    exp_q.push_back({1'b1, 16'h2222, 16'h5A5A});
    do_cmd(1'b0, 1'b1, 16'h2222, 16'h5A5A);
    wait_done();
    check(exp_q.size() == 0, "R3 write to port 1", exp_q.size(), 33'd0);

    // start while busy is ignored
    cur_port = 0; w0 = nwrites;
    exp_q.push_back({1'b0, 16'h0040, 16'h0001});
    do_cmd(1'b0, 1'b0, 16'h0040, 16'h0001);
    do_cmd(1'b0, 1'b1, 16'hFFFF, 16'hFFFF);
    wait_done();
    repeat (3) @(negedge clk);
    check(nwrites - w0 == 1, "R5 busy start ignored", nwrites - w0, 33'd1);
    check(!busy, "R5 no queued command", {32'd0, busy}, 33'd0);

    // acknowledge never rises
    cur_port = 1; mode[1] = 1;
    exp_q.push_back({1'b1, 16'h0300, 16'h00AA});
    do_cmd(1'b0, 1'b1, 16'h0300, 16'h00AA);
    wait_done();
    check(last_run[1] == TMO, "R6 enable window", last_run[1], TMO);
    check(tmo_err, "R8 flag after rise timeout", {32'd0, tmo_err}, 33'd1);
    repeat (5) @(negedge clk);
    check(tmo_err, "R8 flag held while idle", {32'd0, tmo_err}, 33'd1);
    mode[1] = 0;

    // acknowledge stuck high
    cur_port = 0; mode[0] = 2;
    exp_q.push_back({1'b0, 16'h0301, 16'h00BB});
    do_cmd(1'b0, 1'b0, 16'h0301, 16'h00BB);
    wait_done();
    check(last_done_cyc - fall_cyc[0] == TMO, "R7 release window",
          last_done_cyc - fall_cyc[0], TMO);
    check(tmo_err, "R7 flag after fall timeout", {32'd0, tmo_err}, 33'd1);
    @(negedge clk);
    mode[0] = 0; ack_r[0] = 1'b0;
    repeat (2) @(negedge clk);

    // next start clears the flag
    exp_q.push_back({1'b0, 16'h0302, 16'h00CC});
    do_cmd(1'b0, 1'b0, 16'h0302, 16'h00CC);
    check(!tmo_err, "R8 flag cleared by start", {32'd0, tmo_err}, 33'd0);
    wait_done();
    check(!tmo_err, "R8 clean write", {32'd0, tmo_err}, 33'd0);

    // init sequence with junk command fields
    cur_port = -1; dly[0] = 2; dly[1] = 1; w0 = nwrites;
    for (int ph = 0; ph < 2; ph++)
      for (int ln = 0; ln < LANES; ln++)
        exp_q.push_back({1'(ph), 16'h1008 + 16'(ln * 256), INIT_WORD});
    do_cmd(1'b1, 1'b1, 16'h7777, 16'h1111);
    wait_done();
    check(nwrites - w0 == 2 * LANES, "R10 init write count", nwrites - w0, 2 * LANES);
    check(exp_q.size() == 0, "R10 init order", exp_q.size(), 33'd0);
    check(first_we_cyc - sel_rise_cyc == SETTLE + 2, "R9 settle delay",
          first_we_cyc - sel_rise_cyc, SETTLE + 2);
    check(phy0_sel && phy1_sel, "R9 selects high", {31'd0, phy0_sel, phy1_sel}, 33'd3);

    // selects stay high over a later single write
    cur_port = 1;
    exp_q.push_back({1'b1, 16'h0010, 16'h8001});
    do_cmd(1'b0, 1'b1, 16'h0010, 16'h8001);
    wait_done();
    check(exp_q.size() == 0 && phy1_sel, "R9 selects sticky", exp_q.size(), 33'd0);

    // reset clears selects
    cur_port = -1;
    do_reset();
    @(negedge clk);
    check_idle("R1 R9 reset clears");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule